// File: doc/BRIEF.md
# Multiplexed Segment LCD Sequencer

This block produces the digital drive control for a multiplexed segment LCD. Software writes segment bits into a bank of 8-bit display registers. An external prescaler pulses `slot_tick_i` once per common-line slot. Each frame visits the active common lines in turn, starting at COM0. For the common line being visited, the block picks that line's slice of display memory. It then issues a 2-bit level code for every COM and SEG pin, together with per-pin output enables and one buffer-enable.

Display data passes through a shadow copy, which is refreshed only when a frame starts. The polarity of the waveforms flips on each frame so that the display sees no net DC. The level buffers stay on for a programmable number of clock cycles at the start of each slot. After that, every pin is tri-stated. A supply-ready input holds all outputs off until the LCD supply is good. The analog levels themselves are produced outside this block.

Top module: `lcd_mux_seq`

## Requirements
- R1: After reset the slot index is 0, the phase is 0 and the shadow data is all zero. With `duty_sel_i`=2, `bias_third_i`=1, supply good and the buffers on, COM0 reads code 3, COM1 and COM2 read code 1, COM3 is disabled, and every SEG pin reads code 2.
- R2: The number of active common lines is `duty_sel_i`+1. Each slot tick moves to the next common line in ascending order. The tick that leaves the last active common line returns to COM0 and starts a new frame.
- R3: Register a (0..19) is written when `wr_en_i` is high and `wr_addr_i`=a. Common line r takes its data from registers 5r..5r+4, and SEG pin s maps to bit s%8 of register 5r+s/8. The whole bank is copied to the shadow only on a frame-start tick. Writes made during a frame first appear in the following frame.
- R4: Level codes are 0=ground, 1=lower intermediate (or the single mid level under 1/2 bias), 2=upper intermediate and 3=full. The selected COM reads code 3 in phase 0 and code 0 in phase 1.
- R5: Under 1/3 bias, a non-selected active COM reads code 1 in phase 0 and code 2 in phase 1. Under 1/2 bias it reads code 1 in both phases. COM pins at an index above `duty_sel_i` have their output enable at 0.
- R6: A SEG pin whose bit is 1 reads code 0 in phase 0 and code 3 in phase 1.
- R7: A SEG pin whose bit is 0 reads code 2 in phase 0 and code 1 in phase 1 under 1/3 bias. Under 1/2 bias, and under static drive, it reads the same code as the selected COM.
- R8: With `duty_sel_i`=0 (static drive), `bias_third_i` has no effect on any output, and only COM0 is enabled.
- R9: `buf_en_o` and the enables of all active pins are high for `drive_time_i`+1 clock cycles, counted from the edge that takes a slot tick (or from reset), and are low after that until the next tick. A value of 7 keeps them high for the whole slot.
- R10: While `supply_ok_i` is low, `buf_en_o` and every output enable are 0. Slot timing keeps advancing during that time.
- R11: The phase flips on every frame start, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_tick_i | input | 1 | One-cycle pulse that advances to the next slot |
| duty_sel_i | input | 2 | Number of active common lines minus one |
| bias_third_i | input | 1 | 1: 1/3 bias, 0: 1/2 bias |
| drive_time_i | input | 3 | Buffer on-time per slot, in cycles minus one (7 = whole slot) |
| supply_ok_i | input | 1 | LCD supply has reached its target |
| wr_en_i | input | 1 | Display register write strobe |
| wr_addr_i | input | 5 | Display register index |
| wr_data_i | input | 8 | Display register write data |
| com_lvl_o | output | 8 | 2-bit level code per COM pin, COM c at bits 2c+1:2c |
| com_oe_o | output | 4 | Output enable per COM pin |
| seg_lvl_o | output | 80 | 2-bit level code per SEG pin, SEG s at bits 2s+1:2s |
| seg_oe_o | output | 40 | Output enable per SEG pin |
| buf_en_o | output | 1 | Level buffer enable |

## Verification
The outputs are decoded combinationally from the state registers. The effect of a tick, a frame-start latch or a register write therefore shows right after the rising edge that samples it, with no extra pipeline stage. The drive window stays open while a saturating cycle counter, cleared by that same edge, is no greater than `drive_time_i`. This makes the enable high for exactly `drive_time_i`+1 sampling points after a tick. The bench drives inputs on falling edges and reads outputs on the falling edge after each rising edge. It counts every rising edge between a tick and a check. A mid-frame write is therefore expected to stay invisible for the rest of that frame and to appear one frame later.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    LVL_GND  = 2'd0,
    LVL_LO   = 2'd1,
    LVL_HI   = 2'd2,
    LVL_FULL = 2'd3
  } lvl_e;

  typedef struct packed {
    lvl_e sel;
    lvl_e nsel;
    lvl_e on;
    lvl_e off;
  } lvl_set_t;

  function automatic lvl_set_t pick_levels(logic phase, logic static_mode, logic bias_third);
    lvl_set_t s;
    s.sel = phase ? LVL_GND  : LVL_FULL;
    s.on  = phase ? LVL_FULL : LVL_GND;
    if (static_mode || !bias_third) begin
      s.nsel = LVL_LO;
      s.off  = s.sel;
    end else begin
      s.nsel = phase ? LVL_HI : LVL_LO;
      s.off  = phase ? LVL_LO : LVL_HI;
    end
    return s;
  endfunction

endpackage

// File: rtl/lcd_disp_bank.sv
module lcd_disp_bank #(
  parameter int NUM_COM      = 4,
  parameter int REGS_PER_COM = 5,
  localparam int NUM_REGS    = NUM_COM * REGS_PER_COM,
  localparam int ADDR_W      = $clog2(NUM_REGS),
  localparam int SEG_W       = REGS_PER_COM * 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [7:0]                      wr_data_i,
  input  logic                            latch_i,
  output logic [NUM_COM-1:0][SEG_W-1:0]   shadow_o
);

  logic [NUM_REGS-1:0][7:0]         bank_q;
  logic [NUM_COM-1:0][SEG_W-1:0]    shadow_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    bank_q[r] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(r))   bank_q[r] <= wr_data_i;
    end
  end

  // shadow copy refreshed only when a frame begins
  for (genvar c = 0; c < NUM_COM; c++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      shadow_q[c] <= '0;
      else if (latch_i) shadow_q[c] <= bank_q[c*REGS_PER_COM +: REGS_PER_COM];
    end
  end

  assign shadow_o = shadow_q;

  assert_shadow_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(shadow_q));

endmodule

// File: rtl/lcd_slot_timer.sv
module lcd_slot_timer #(
  parameter int NUM_COM = 4,
  parameter int DT_W    = 3,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [IDX_W-1:0] duty_m1_i,
  input  logic [DT_W-1:0]  drive_time_i,
  output logic [IDX_W-1:0] com_idx_o,
  output logic             phase_o,
  output logic             frame_start_o,
  output logic             drive_on_o
);

  logic [IDX_W-1:0] idx_q;
  logic             phase_q;
  logic [DT_W-1:0]  dt_q;
  logic             wrap;

  // >= lets a duty reduction mid-frame wrap on the next tick
  assign wrap          = idx_q >= duty_m1_i;
  assign frame_start_o = tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      phase_q <= 1'b0;
      dt_q    <= '0;
    end else if (tick_i) begin
      dt_q <= '0;
      if (wrap) begin
        idx_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (dt_q != '1) begin
      dt_q <= dt_q + 1'b1;
    end
  end

  assign com_idx_o  = idx_q;
  assign phase_o    = phase_q;
  assign drive_on_o = dt_q <= drive_time_i;

  assert_wrap_to_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> com_idx_o == '0);

  assert_ascend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !frame_start_o |=> com_idx_o == IDX_W'($past(com_idx_o) + 1'b1));

  assert_phase_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_o |=> $stable(phase_o));

  assert_phase_flip_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> phase_o != $past(phase_o));

  assert_drive_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> drive_on_o);

endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_seq_pkg::*;
#(
  parameter int NUM_COM = 4,
  parameter int SEG_W   = 40,
  localparam int IDX_W  = $clog2(NUM_COM)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [IDX_W-1:0]              com_idx_i,
  input  logic [IDX_W-1:0]              duty_m1_i,
  input  logic                          phase_i,
  input  logic                          bias_third_i,
  input  logic                          drive_on_i,
  input  logic                          supply_ok_i,
  input  logic [SEG_W-1:0]              seg_bits_i,
  output logic [NUM_COM-1:0][1:0]       com_lvl_o,
  output logic [NUM_COM-1:0]            com_oe_o,
  output logic [SEG_W-1:0][1:0]         seg_lvl_o,
  output logic [SEG_W-1:0]              seg_oe_o,
  output logic                          buf_en_o
);

  lvl_set_t lv;
  logic     static_mode;

  assign static_mode = duty_m1_i == '0;
  assign lv          = pick_levels(phase_i, static_mode, bias_third_i);
  assign buf_en_o    = supply_ok_i && drive_on_i;

  for (genvar c = 0; c < NUM_COM; c++) begin : g_com
    logic used;
    assign used         = IDX_W'(c) <= duty_m1_i;
    assign com_lvl_o[c] = !used                    ? LVL_GND :
                          (IDX_W'(c) == com_idx_i) ? lv.sel  : lv.nsel;
    assign com_oe_o[c]  = buf_en_o && used;
  end

  for (genvar s = 0; s < SEG_W; s++) begin : g_seg
    assign seg_lvl_o[s] = seg_bits_i[s] ? lv.on : lv.off;
    assign seg_oe_o[s]  = buf_en_o;
  end

  logic [NUM_COM-1:0] full_hit;
  for (genvar c = 0; c < NUM_COM; c++) begin : g_hit
    assign full_hit[c] = com_oe_o[c] && (com_lvl_o[c] == LVL_FULL);
  end

  assert_inhibit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |-> !buf_en_o && com_oe_o == '0 && seg_oe_o == '0);

  assert_one_selected_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_en_o && !phase_i |-> $countones(full_hit) == 1);

  assert_static_com_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    static_mode |-> com_oe_o[NUM_COM-1:1] == '0);

endmodule

// File: rtl/lcd_mux_seq.sv
module lcd_mux_seq #(
  parameter int NUM_COM      = 4,
  parameter int REGS_PER_COM = 5,
  parameter int DT_W         = 3,
  localparam int IDX_W       = $clog2(NUM_COM),
  localparam int NUM_REGS    = NUM_COM * REGS_PER_COM,
  localparam int ADDR_W      = $clog2(NUM_REGS),
  localparam int NUM_SEG     = REGS_PER_COM * 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   slot_tick_i,
  input  logic [IDX_W-1:0]       duty_sel_i,
  input  logic                   bias_third_i,
  input  logic [DT_W-1:0]        drive_time_i,
  input  logic                   supply_ok_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [7:0]             wr_data_i,
  output logic [2*NUM_COM-1:0]   com_lvl_o,
  output logic [NUM_COM-1:0]     com_oe_o,
  output logic [2*NUM_SEG-1:0]   seg_lvl_o,
  output logic [NUM_SEG-1:0]     seg_oe_o,
  output logic                   buf_en_o
);

  logic [IDX_W-1:0]                com_idx;
  logic                            phase;
  logic                            frame_start;
  logic                            drive_on;
  logic [NUM_COM-1:0][NUM_SEG-1:0] shadow;
  logic [NUM_COM-1:0][1:0]         com_lvl;
  logic [NUM_SEG-1:0][1:0]         seg_lvl;

  lcd_slot_timer #(.NUM_COM(NUM_COM), .DT_W(DT_W)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (slot_tick_i),
    .duty_m1_i     (duty_sel_i),
    .drive_time_i  (drive_time_i),
    .com_idx_o     (com_idx),
    .phase_o       (phase),
    .frame_start_o (frame_start),
    .drive_on_o    (drive_on)
  );

  lcd_disp_bank #(.NUM_COM(NUM_COM), .REGS_PER_COM(REGS_PER_COM)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .latch_i   (frame_start),
    .shadow_o  (shadow)
  );

  lcd_level_enc #(.NUM_COM(NUM_COM), .SEG_W(NUM_SEG)) u_enc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .com_idx_i    (com_idx),
    .duty_m1_i    (duty_sel_i),
    .phase_i      (phase),
    .bias_third_i (bias_third_i),
    .drive_on_i   (drive_on),
    .supply_ok_i  (supply_ok_i),
    .seg_bits_i   (shadow[com_idx]),
    .com_lvl_o    (com_lvl),
    .com_oe_o     (com_oe_o),
    .seg_lvl_o    (seg_lvl),
    .seg_oe_o     (seg_oe_o),
    .buf_en_o     (buf_en_o)
  );

  assign com_lvl_o = com_lvl;
  assign seg_lvl_o = seg_lvl;

  assert_seg_oe_track_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_oe_o == {NUM_SEG{buf_en_o}});

endmodule

// File: tb/lcd_mux_seq_tb.sv
module lcd_mux_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCOM = 4;
  localparam int RPC  = 5;
  localparam int NSEG = 40;

  typedef struct packed {
    logic [1:0] duty_m1;
    logic       bias3;
    logic [1:0] sel0, sel1, ns0, ns1, on0, on1, off0, off1;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{2'd3, 1'b1, 2'd3, 2'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd2, 2'd1},
    '{2'd3, 1'b0, 2'd3, 2'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 2'd0},
    '{2'd2, 1'b1, 2'd3, 2'd0, 2'd1, 2'd2, 2'd0, 2'd3, 2'd2, 2'd1},
    '{2'd1, 1'b0, 2'd3, 2'd0, 2'd1, 2'd1, 2'd0, 2'd3, 2'd3, 2'd0},
    '{2'd0, 1'b1, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 2'd0},
    '{2'd0, 1'b0, 2'd3, 2'd0, 2'd0, 2'd0, 2'd0, 2'd3, 2'd3, 2'd0}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              slot_tick = 1'b0;
  logic [1:0]        duty_sel = 2'd3;
  logic              bias_third = 1'b1;
  logic [2:0]        drive_time = 3'd7;
  logic              supply_ok = 1'b1;
  logic              wr_en = 1'b0;
  logic [4:0]        wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [2*NCOM-1:0] com_lvl;
  logic [NCOM-1:0]   com_oe;
  logic [2*NSEG-1:0] seg_lvl;
  logic [NSEG-1:0]   seg_oe;
  logic              buf_en;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mux_seq u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .slot_tick_i  (slot_tick),
    .duty_sel_i   (duty_sel),
    .bias_third_i (bias_third),
    .drive_time_i (drive_time),
    .supply_ok_i  (supply_ok),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .com_lvl_o    (com_lvl),
    .com_oe_o     (com_oe),
    .seg_lvl_o    (seg_lvl),
    .seg_oe_o     (seg_oe),
    .buf_en_o     (buf_en)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int e, int r, int k);
    return 8'(e*37 + r*59 + k*13 + 27) ^ 8'hA5;
  endfunction

  function automatic int com_at(int c);
    return int'(com_lvl[2*c +: 2]);
  endfunction

  function automatic int seg_at(int s);
    return int'(seg_lvl[2*s +: 2]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; slot_tick = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick();
    slot_tick = 1'b1;
    @(negedge clk);
    slot_tick = 1'b0;
  endtask

  task automatic wr_reg(int a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_slot(int e, int r, bit ph);
    vec_t v = VECS[e];
    int sel = ph ? int'(v.sel1) : int'(v.sel0);
    int ns  = ph ? int'(v.ns1)  : int'(v.ns0);
    int on  = ph ? int'(v.on1)  : int'(v.on0);
    int off = ph ? int'(v.off1) : int'(v.off0);
    for (int c = 0; c < NCOM; c++) begin
      if (c <= int'(v.duty_m1)) begin
        if (c == r) chk("R2 R4 R11 selected COM", com_at(c), sel);
        else        chk("R5 non-selected COM", com_at(c), ns);
        chk("R5 active COM enable", int'(com_oe[c]), 1);
      end else begin
        chk("R5 R8 unused COM enable", int'(com_oe[c]), 0);
      end
    end
    for (int s = 0; s < NSEG; s++) begin
      logic [7:0] b = pat(e, r, s/8);
      if (b[s%8]) chk("R3 R6 energized SEG", seg_at(s), on);
      else        chk("R3 R7 R8 non-energized SEG", seg_at(s), off);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state
    duty_sel = 2'd2; bias_third = 1'b1; drive_time = 3'd7; supply_ok = 1'b1;
    do_reset();
    chk("R1 COM0 level", com_at(0), 3);
    chk("R1 COM1 level", com_at(1), 1);
    chk("R1 COM2 level", com_at(2), 1);
    chk("R1 COM3 enable", int'(com_oe[3]), 0);
    chk("R1 buffer enable", int'(buf_en), 1);
    for (int s = 0; s < NSEG; s++) chk("R1 SEG level", seg_at(s), 2);
    wr_reg(0, 8'hFF);
    chk("R3 write before first frame start hidden", seg_at(0), 2);

    // table walk
    for (int e = 0; e < 6; e++) begin
      duty_sel = VECS[e].duty_m1; bias_third = VECS[e].bias3;
      drive_time = 3'd7; supply_ok = 1'b1;
      do_reset();
      for (int a = 0; a < NCOM*RPC; a++) wr_reg(a, pat(e, a/RPC, a%RPC));
      for (int t = 0; t <= int'(VECS[e].duty_m1); t++) do_tick();
      for (int f = 0; f < 2; f++) begin
        for (int r = 0; r <= int'(VECS[e].duty_m1); r++) begin
          check_slot(e, r, (f == 0));
          do_tick();
        end
      end
    end

    // R8: static drive, bias toggled on the fly has no effect
    duty_sel = 2'd0; bias_third = 1'b1; do_reset();
    wr_reg(0, 8'h01); do_tick();
    bias_third = 1'b0; #1;
    chk("R8 static SEG0 on, bias 1/2", seg_at(0), 3);
    chk("R8 static SEG1 off, bias 1/2", seg_at(1), 0);
    bias_third = 1'b1; #1;
    chk("R8 static SEG1 off, bias 1/3", seg_at(1), 0);
    chk("R8 static COM0", com_at(0), 0);

    // R3: mid-frame write appears one frame later
    duty_sel = 2'd1; bias_third = 1'b1; drive_time = 3'd7; do_reset();
    for (int a = 0; a < 10; a++) wr_reg(a, 8'hFF);
    do_tick(); do_tick();
    wr_reg(5, 8'h00);
    do_tick();
    chk("R3 mid-frame write hidden", seg_at(0), 3);
    do_tick(); do_tick();
    chk("R3 write visible next frame", seg_at(0), 2);
    chk("R3 untouched register", seg_at(8), 0);

    // R9: drive-time window
    duty_sel = 2'd3; drive_time = 3'd2; do_reset();
    do_tick();
    for (int n = 0; n < 6; n++) begin
      chk("R9 buffer window dt=2", int'(buf_en), (n <= 2) ? 1 : 0);
      chk("R9 SEG enable window dt=2", int'(seg_oe[0]), (n <= 2) ? 1 : 0);
      chk("R9 COM enable window dt=2", int'(com_oe[1]), (n <= 2) ? 1 : 0);
      @(negedge clk);
    end
    do_tick();
    chk("R9 restart after tick", int'(buf_en), 1);
    drive_time = 3'd0; do_tick();
    chk("R9 dt=0 first cycle", int'(buf_en), 1);
    @(negedge clk);
    chk("R9 dt=0 second cycle", int'(buf_en), 0);
    drive_time = 3'd7; do_tick();
    repeat (20) @(negedge clk);
    chk("R9 dt=7 whole slot", int'(buf_en), 1);

    // R10: inhibit while supply not ready, timing continues
    duty_sel = 2'd3; bias_third = 1'b1; drive_time = 3'd7; do_reset();
    supply_ok = 1'b0; #1;
    chk("R10 buffer off", int'(buf_en), 0);
    chk("R10 COM enables off", int'(com_oe), 0);
    chk("R10 SEG enables off", int'(seg_oe != '0), 0);
    do_tick(); do_tick();
    chk("R10 still off after ticks", int'(buf_en), 0);
    supply_ok = 1'b1; #1;
    chk("R10 R2 slot advanced while inhibited", com_at(2), 3);
    chk("R10 COM2 enable restored", int'(com_oe[2]), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule